// File: doc/BRIEF.md
# External-Memory Byte Queue Sequencer

This block turns a large external memory into a first-in first-out byte queue. Bytes that a serial receiver delivers are written one at a time through a handshaked memory command port. On a drain request the whole queue is read back in arrival order, and each byte is handed to a serial transmitter. The block does nothing until the memory reports that its calibration is complete.

Two pointers track the queue. Each is one bit wider than the memory address, and only the lower bits go out on the address bus. The extra top bit tells a full queue from an empty one. A clear request discards the stored data by resetting both pointers. A free-running counter records every byte that has ever arrived, and neither a clear nor a drain touches it. The calibration status is passed straight through so that an indicator can show it.

Top module: `ext_fifo_seq`

## Requirements
- R1: No memory command and no transmit start is issued before `calib_done` has been seen high. `calib_status` always equals `calib_done`.
- R2: Each accepted byte is written with `mem_cmd_we`=1 at the low `ADDR_W` bits of the write pointer. Successive writes go to consecutive addresses, wrapping modulo 2^ADDR_W.
- R3: When `mem_cmd_valid` is high and `mem_cmd_ready` is low, the next cycle has `mem_cmd_valid` still high, with `mem_cmd_we`, `mem_cmd_addr` and `mem_cmd_wdata` unchanged.
- R4: `fifo_empty` is high exactly when the two pointers match in every bit, including the top bit. After reset it is 1 and `fifo_full` is 0.
- R5: `fifo_full` is high when the low address bits of the pointers match and their top bits differ. A byte received while the queue is full is not written.
- R6: After `drain_req`, every stored byte is read (`mem_cmd_we`=0) in order from the read pointer. Each returned byte appears on `tx_data` with a one-cycle `tx_start` pulse, until the queue is empty. A drain request on an empty queue issues no command.
- R7: A read command is issued only after the previous read's `mem_rd_valid` has returned and `tx_busy` was low in the cycle before.
- R8: `clear_req` sets both pointers to zero, so `fifo_empty` becomes 1, the next write goes to address 0, and a following drain sends nothing. `rx_count` is not changed.
- R9: `rx_count` increases by one for every cycle in which `rx_valid` is high, including dropped bytes. Neither clear nor drain resets it.
- R10: A byte that arrives before calibration, or while a write or a drain is in progress, is dropped and does not advance the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calib_done | input | 1 | Memory calibration complete |
| rx_valid | input | 1 | One-cycle strobe: received byte present |
| rx_data | input | DATA_W | Received byte |
| drain_req | input | 1 | Request to send the whole queue |
| clear_req | input | 1 | Request to discard the queue contents |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_we | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | ADDR_W | Memory address |
| mem_cmd_wdata | output | DATA_W | Write data |
| mem_cmd_ready | input | 1 | Memory accepts the command this cycle |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | DATA_W | Returned read data |
| tx_start | output | 1 | One-cycle transmit start |
| tx_data | output | DATA_W | Byte to transmit |
| tx_busy | input | 1 | Transmitter busy |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| rx_count | output | CNT_W | Total bytes received (wraps) |
| calib_status | output | 1 | Copy of calib_done |

## Verification
The bench goes after pointer wrap-around. A full drain that begins mid-memory crosses the top address, and a design that compared pointers without the extra bit would read a full queue as empty and send nothing. It fills the queue to exactly the memory depth and offers one more byte: a design without the full test would overwrite the oldest byte, and the drain would then come out one byte short and out of order. A memory that stalls its ready on a fixed pattern exposes a command that changes before it is accepted. A byte offered during a drain, and a clear followed by a drain, show whether stale pointers or leaked writes survive. Every clock, the received-byte count is compared with the model to catch a counter that a clear resets.

// File: rtl/ext_fifo_pkg.sv
package ext_fifo_pkg;
  typedef enum logic [2:0] {
    ST_CALWAIT = 3'd0,
    ST_IDLE    = 3'd1,
    ST_WRITE   = 3'd2,
    ST_RDCMD   = 3'd3,
    ST_RDWAIT  = 3'd4,
    ST_TXGO    = 3'd5,
    ST_TXWAIT  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/fifo_ptr_pair.sv
module fifo_ptr_pair #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_inc,
  input  logic              rd_inc,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              empty,
  output logic              full
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return p + PW'(1);
  endfunction

  function automatic logic ptrs_empty(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w == r;
  endfunction

  function automatic logic ptrs_full(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return (w[ADDR_W-1:0] == r[ADDR_W-1:0]) && (w[ADDR_W] != r[ADDR_W]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_inc) wr_ptr <= ptr_step(wr_ptr);
      if (rd_inc) rd_ptr <= ptr_step(rd_ptr);
    end
  end

  assign wr_addr = wr_ptr[ADDR_W-1:0];
  assign rd_addr = rd_ptr[ADDR_W-1:0];
  assign empty   = ptrs_empty(wr_ptr, rd_ptr);
  assign full    = ptrs_full(wr_ptr, rd_ptr);
endmodule

// File: rtl/rx_byte_counter.sv
module rx_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count_step(count);
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import ext_fifo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              calib_done,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              drain_req,
  input  logic              clear_req,
  input  logic              empty,
  input  logic              full,
  input  logic              cmd_ready,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              tx_busy,
  output logic              cmd_valid,
  output logic              cmd_we,
  output logic [DATA_W-1:0] wdata,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_data,
  output logic              wr_inc,
  output logic              rd_inc,
  output logic              ptr_clr
);
  seq_state_t state_q, state_d;
  logic drain_pend_q, clear_pend_q;
  logic take_rx, start_drain, drop_drain;

  always_comb begin
    state_d     = state_q;
    wr_inc      = 1'b0;
    rd_inc      = 1'b0;
    ptr_clr     = 1'b0;
    take_rx     = 1'b0;
    start_drain = 1'b0;
    drop_drain  = 1'b0;
    unique case (state_q)
      ST_CALWAIT: if (calib_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (clear_pend_q) begin
          ptr_clr = 1'b1;
        end else if (rx_valid && !full) begin
          take_rx = 1'b1;
          state_d = ST_WRITE;
        end else if (drain_pend_q) begin
          if (empty) begin
            drop_drain = 1'b1;
          end else begin
            start_drain = 1'b1;
            state_d     = ST_RDCMD;
          end
        end
      end
      ST_WRITE: if (cmd_ready) begin
        wr_inc  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RDCMD:  if (cmd_ready) state_d = ST_RDWAIT;
      ST_RDWAIT: if (rd_valid) begin
        rd_inc  = 1'b1;
        state_d = ST_TXGO;
      end
      ST_TXGO:   state_d = ST_TXWAIT;
      ST_TXWAIT: if (!tx_busy) state_d = empty ? ST_IDLE : ST_RDCMD;
      default:   state_d = ST_CALWAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_CALWAIT;
      drain_pend_q <= 1'b0;
      clear_pend_q <= 1'b0;
      wdata        <= '0;
      tx_data      <= '0;
    end else begin
      state_q      <= state_d;
      drain_pend_q <= drain_req | (drain_pend_q & ~(start_drain | drop_drain));
      clear_pend_q <= clear_req | (clear_pend_q & ~ptr_clr);
      if (take_rx) wdata   <= rx_data;
      if (rd_inc)  tx_data <= rd_data;
    end
  end

  assign cmd_valid = (state_q == ST_WRITE) || (state_q == ST_RDCMD);
  assign cmd_we    = (state_q == ST_WRITE);
  assign tx_start  = (state_q == ST_TXGO);
endmodule

// File: rtl/ext_fifo_seq.sv
module ext_fifo_seq #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              calib_done,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              drain_req,
  input  logic              clear_req,
  output logic              mem_cmd_valid,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [DATA_W-1:0] mem_cmd_wdata,
  input  logic              mem_cmd_ready,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_busy,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [CNT_W-1:0]  rx_count,
  output logic              calib_status
);
  logic              wr_accept_evt;
  logic              rd_return_evt;
  logic              ptr_clr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  fifo_ptr_pair #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ptr_clr_evt),
    .wr_inc  (wr_accept_evt),
    .rd_inc  (rd_return_evt),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  rx_byte_counter #(.CNT_W(CNT_W)) u_rxcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rx_valid),
    .count (rx_count)
  );

  seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .calib_done(calib_done),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .drain_req (drain_req),
    .clear_req (clear_req),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .cmd_ready (mem_cmd_ready),
    .rd_valid  (mem_rd_valid),
    .rd_data   (mem_rd_data),
    .tx_busy   (tx_busy),
    .cmd_valid (mem_cmd_valid),
    .cmd_we    (mem_cmd_we),
    .wdata     (mem_cmd_wdata),
    .tx_start  (tx_start),
    .tx_data   (tx_data),
    .wr_inc    (wr_accept_evt),
    .rd_inc    (rd_return_evt),
    .ptr_clr   (ptr_clr_evt)
  );

  assign mem_cmd_addr = mem_cmd_we ? wr_addr : rd_addr;
  assign calib_status = calib_done;
endmodule

// File: rtl/ext_fifo_seq_chk.sv
module ext_fifo_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              calib_done,
  input logic              rx_valid,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_we,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic [DATA_W-1:0] mem_cmd_wdata,
  input logic              mem_cmd_ready,
  input logic              tx_start,
  input logic              tx_busy,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic [CNT_W-1:0]  rx_count,
  input logic              calib_status,
  input logic              ptr_clr_evt,
  input logic              wr_accept_evt
);
  logic calib_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)          calib_seen <= 1'b0;
    else if (calib_done) calib_seen <= 1'b1;
  end

  assert_gate_until_calib_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !calib_seen |-> (!mem_cmd_valid && !tx_start));

  assert_status_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
    calib_status == calib_done);

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept_evt |=> !fifo_empty);

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_we) && $stable(mem_cmd_addr) && $stable(mem_cmd_wdata)));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));

  assert_no_write_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !(mem_cmd_valid && mem_cmd_we));

  assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_read_after_idle_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cmd_valid && !mem_cmd_we) |-> !$past(tx_busy));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr_evt |=> fifo_empty);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (rx_count == $past(rx_count) + CNT_W'(1)));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(rx_count));
endmodule

bind ext_fifo_seq ext_fifo_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .calib_done    (calib_done),
  .rx_valid      (rx_valid),
  .mem_cmd_valid (mem_cmd_valid),
  .mem_cmd_we    (mem_cmd_we),
  .mem_cmd_addr  (mem_cmd_addr),
  .mem_cmd_wdata (mem_cmd_wdata),
  .mem_cmd_ready (mem_cmd_ready),
  .tx_start      (tx_start),
  .tx_busy       (tx_busy),
  .fifo_empty    (fifo_empty),
  .fifo_full     (fifo_full),
  .rx_count      (rx_count),
  .calib_status  (calib_status),
  .ptr_clr_evt   (ptr_clr_evt),
  .wr_accept_evt (wr_accept_evt)
);

// File: tb/test_ext_fifo_seq.sv
module test_ext_fifo_seq;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 12;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic calib_done = 1'b0;
  logic rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic drain_req = 1'b0;
  logic clear_req = 1'b0;
  logic mem_cmd_valid, mem_cmd_we;
  logic [ADDR_W-1:0] mem_cmd_addr;
  logic [DATA_W-1:0] mem_cmd_wdata;
  logic mem_cmd_ready = 1'b0;
  logic mem_rd_valid = 1'b0;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic tx_start;
  logic [DATA_W-1:0] tx_data;
  logic tx_busy = 1'b0;
  logic fifo_empty, fifo_full, calib_status;
  logic [CNT_W-1:0] rx_count;

  always #2 clk = ~clk;

  ext_fifo_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_ext_fifo_seq (
    .clk(clk), .rst_n(rst_n), .calib_done(calib_done),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .drain_req(drain_req), .clear_req(clear_req),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_we(mem_cmd_we),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
    .mem_cmd_ready(mem_cmd_ready), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .tx_start(tx_start), .tx_data(tx_data),
    .tx_busy(tx_busy), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .rx_count(rx_count), .calib_status(calib_status)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory and transmitter models
  logic [DATA_W-1:0] mem [DEPTH];
  int cyc = 0;
  int rd_timer = 0;
  logic [ADDR_W-1:0] rd_addr_q = '0;
  int busy_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_cmd_ready <= (cyc % 3) != 1;
    mem_rd_valid <= 1'b0;
    if (mem_cmd_valid && mem_cmd_ready) begin
      if (mem_cmd_we) mem[mem_cmd_addr] <= mem_cmd_wdata;
      else begin
        rd_timer  <= 3;
        rd_addr_q <= mem_cmd_addr;
      end
    end else if (rd_timer > 0) begin
      rd_timer <= rd_timer - 1;
      if (rd_timer == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem[rd_addr_q];
      end
    end
    if (tx_start) begin
      tx_busy  <= 1'b1;
      busy_cnt <= 4;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) tx_busy <= 1'b0;
    end
  end

  // behavioural reference model
  logic [DATA_W-1:0] exp_store[$];
  logic [DATA_W-1:0] tx_exp[$];
  int model_count = 0;
  int occ = 0;
  int wr_idx = 0;
  int rd_idx = 0;
  int writes = 0;
  int tx_seen = 0;
  int last_wr_addr = -1;
  bit rx_accept = 1'b0;
  bit calib_seen_tb = 1'b0;
  bit rd_outstanding = 1'b0;
  bit prev_stall = 1'b0;
  logic prev_we;
  logic [ADDR_W-1:0] prev_addr;
  logic [DATA_W-1:0] prev_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_count == CNT_W'(model_count), "R9", "rx_count", int'(rx_count), model_count % (1 << CNT_W));
      chk(fifo_empty == (occ == 0), "R4", "fifo_empty", int'(fifo_empty), int'(occ == 0));
      chk(fifo_full == (occ == DEPTH), "R5", "fifo_full", int'(fifo_full), int'(occ == DEPTH));
      chk(calib_status == calib_done, "R1", "calib_status", int'(calib_status), int'(calib_done));
      if (!calib_seen_tb)
        chk(!mem_cmd_valid && !tx_start, "R1", "activity before calibration", int'(mem_cmd_valid), 0);
      if (prev_stall)
        chk(mem_cmd_valid && mem_cmd_we == prev_we && mem_cmd_addr == prev_addr &&
            (!prev_we || mem_cmd_wdata == prev_wdata), "R3", "command changed while stalled",
            int'(mem_cmd_addr), int'(prev_addr));
      if (mem_cmd_valid && mem_cmd_ready && mem_cmd_we) begin
        logic [DATA_W-1:0] e;
        e = (exp_store.size() > 0) ? exp_store.pop_front() : 'x;
        chk(mem_cmd_addr == ADDR_W'(wr_idx), "R2", "write address", int'(mem_cmd_addr), wr_idx % DEPTH);
        chk(mem_cmd_wdata === e, "R2", "write data", int'(mem_cmd_wdata), int'(e));
        last_wr_addr = int'(mem_cmd_addr);
        wr_idx++; occ++; writes++;
        tx_exp.push_back(mem_cmd_wdata);
      end
      if (mem_cmd_valid && mem_cmd_ready && !mem_cmd_we) begin
        chk(mem_cmd_addr == ADDR_W'(rd_idx), "R6", "read address", int'(mem_cmd_addr), rd_idx % DEPTH);
        chk(!rd_outstanding && !tx_busy, "R7", "read issued too early", int'(tx_busy), 0);
        rd_outstanding = 1'b1;
        rd_idx++;
      end
      if (mem_rd_valid) begin
        rd_outstanding = 1'b0;
        occ--;
      end
      if (tx_start) begin
        logic [DATA_W-1:0] t;
        t = (tx_exp.size() > 0) ? tx_exp.pop_front() : 'x;
        chk(tx_data === t, "R6", "tx byte order", int'(tx_data), int'(t));
        tx_seen++;
      end
      if (rx_valid) begin
        model_count++;
        if (rx_accept) exp_store.push_back(rx_data);
      end
      prev_stall = mem_cmd_valid && !mem_cmd_ready;
      prev_we    = mem_cmd_we;
      prev_addr  = mem_cmd_addr;
      prev_wdata = mem_cmd_wdata;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [DATA_W-1:0] b, input bit accept);
    tick();
    rx_valid = 1'b1; rx_data = b; rx_accept = accept;
    tick();
    rx_valid = 1'b0; rx_accept = 1'b0;
    repeat (10) tick();
  endtask

  task automatic pulse_drain();
    tick(); drain_req = 1'b1;
    tick(); drain_req = 1'b0;
  endtask

  task automatic wait_drain();
    repeat (400) tick();
  endtask

  int w0, t0, c0;

  initial begin
    repeat (5) tick();
    chk(fifo_empty == 1'b1, "R4", "reset empty", int'(fifo_empty), 1);
    chk(fifo_full == 1'b0, "R4", "reset full", int'(fifo_full), 0);
    chk(rx_count == '0, "R9", "reset count", int'(rx_count), 0);
    chk(!mem_cmd_valid && !tx_start, "R1", "reset outputs idle", int'(mem_cmd_valid), 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // R10: byte before calibration is counted but never written
    send_byte(8'h11, 1'b0);
    chk(writes == 0, "R10", "write before calibration", writes, 0);
    chk(rx_count == CNT_W'(1), "R9", "count before calibration", int'(rx_count), 1);
    pulse_drain();
    repeat (10) tick();
    chk(tx_seen == 0, "R1", "drain before calibration", tx_seen, 0);

    calib_done = 1'b1; calib_seen_tb = 1'b1;
    tick();
    chk(calib_status == 1'b1, "R1", "status follows calibration", int'(calib_status), 1);

    // R2: five writes; the pending drain is dropped on the first empty idle cycle
    for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i), 1'b1);
    chk(writes == 5, "R2", "writes accepted", writes, 5);
    chk(!fifo_empty, "R4", "not empty after writes", int'(fifo_empty), 0);

    // R6: drain five
    pulse_drain(); wait_drain();
    chk(tx_seen == 5, "R6", "bytes transmitted", tx_seen, 5);
    chk(fifo_empty, "R6", "empty after drain", int'(fifo_empty), 1);

    // R5: fill to depth with wrap, then one extra byte
    for (int i = 0; i < DEPTH; i++) send_byte(8'h40 + 8'(i), 1'b1);
    chk(fifo_full, "R5", "full at depth", int'(fifo_full), 1);
    w0 = writes; c0 = int'(rx_count);
    send_byte(8'hEE, 1'b0);
    chk(writes == w0, "R5", "write while full", writes, w0);
    chk(int'(rx_count) == c0 + 1, "R9", "dropped byte counted", int'(rx_count), c0 + 1);

    t0 = tx_seen;
    pulse_drain(); wait_drain();
    chk(tx_seen - t0 == DEPTH, "R6", "full drain across wrap", tx_seen - t0, DEPTH);
    chk(fifo_empty, "R6", "empty after full drain", int'(fifo_empty), 1);

    // R8: clear discards contents, keeps count
    for (int i = 0; i < 3; i++) send_byte(8'h70 + 8'(i), 1'b1);
    c0 = int'(rx_count);
    tick(); clear_req = 1'b1;
    tick(); clear_req = 1'b0;
    tick();
    occ = 0; wr_idx = 0; rd_idx = 0; tx_exp.delete();
    tick();
    chk(fifo_empty, "R8", "empty after clear", int'(fifo_empty), 1);
    chk(int'(rx_count) == c0, "R8", "count kept on clear", int'(rx_count), c0);
    t0 = tx_seen;
    pulse_drain(); wait_drain();
    chk(tx_seen == t0, "R8", "drain after clear sends nothing", tx_seen - t0, 0);
    send_byte(8'h5A, 1'b1);
    chk(last_wr_addr == 0, "R8", "first write after clear", last_wr_addr, 0);

    // R10: byte offered during a drain is dropped
    for (int i = 0; i < 3; i++) send_byte(8'hC0 + 8'(i), 1'b1);
    w0 = writes; t0 = tx_seen;
    pulse_drain();
    repeat (15) tick();
    send_byte(8'h99, 1'b0);
    wait_drain();
    chk(writes == w0, "R10", "write during drain", writes, w0);
    chk(tx_seen - t0 == 4, "R6", "drain count", tx_seen - t0, 4);

    // R6: drain of empty queue issues nothing
    w0 = writes; t0 = tx_seen;
    pulse_drain(); repeat (30) tick();
    chk(tx_seen == t0 && writes == w0, "R6", "empty drain idle", tx_seen - t0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule